// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block is the glue logic that sits beside an 8-bit processor whose 16-bit address space is carried on two buses. The high address byte stays steady for a whole bus cycle. The low byte shares its wires with the data. The block registers the low byte while the address strobe is high. It then joins that byte to the high byte to form the full address, and it decodes the address into chip selects and gated memory strobes.

The map is nested. Everything from 0x2000 upward belongs to a 56K program ROM, and 0x0400 to 0x1FFF is 7K of external RAM. The bottom kilobyte, 0x0000 to 0x03FF, is left to the processor's internal RAM and I/O, so no external memory select fires there. Within that kilobyte, 0x0200 to 0x03FF drives four peripheral latch selects. These are active-low write pulses, and each latch takes its data on the rising edge of its select.

The ROM output enable is held off on every write cycle. The RAM write enable is gated by reset without passing through any register, so a reset blocks the write at once.

A small cycle tracker runs on the system clock and has three states:
- `CYC_IDLE`: no bus cycle is in progress.
- `CYC_ADDR`: the address strobe is high.
- `CYC_DATA`: the data phase.

The transitions are:
- **start** (`CYC_IDLE` to `CYC_ADDR`): taken when the strobe is high.
- **latch** (`CYC_ADDR` to `CYC_DATA`): taken when the strobe falls.
- **finish** (`CYC_DATA` to `CYC_IDLE`): taken when the enable `e_i` is low and the strobe is low.
- **restart** (`CYC_DATA` to `CYC_ADDR`): taken when the strobe is high. It has priority over finish.

Each state holds where its exit condition is false. An active reset returns the tracker to `CYC_IDLE`.

Top module: `membus_decoder`

## Requirements
- R1: While `rst_n` is low, every select and strobe is inactive: `rom_cs_n`, `rom_oe_n`, `ram_cs_n` and `ram_we_n` are high, `int_sel_o` is low and `latch_sel_n` is all ones.
- R2: On each clock edge where `as_i` is high, the low address byte is taken from `ad_i`. It is held while `as_i` stays low. `addr_o` equals `{hi_addr_i, low byte}`, and changes on `ad_i` during the data phase do not alter it.
- R3: During the data phase, `rom_cs_n` is low exactly when the address is 0x2000 or above.
- R4: During the data phase, `ram_cs_n` is low exactly when the address is in 0x0400 to 0x1FFF.
- R5: During the data phase, `int_sel_o` is high exactly when the address is in 0x0000 to 0x03FF. Neither `rom_cs_n` nor `ram_cs_n` is low there.
- R6: 0x0200 to 0x03FF is split into four 128-byte sub-ranges. Sub-range k is selected by address bits [8:7] = k. Bit k of `latch_sel_n` is low only during a write data phase (`rw_i` = 0) with `e_i` high and the address in sub-range k. At most one bit is low, and none is low on reads or outside 0x0200 to 0x03FF.
- R7: `rom_oe_n` is low only in a read data phase (`rw_i` = 1) with `e_i` high and a ROM address. It is high on every write cycle.
- R8: `ram_we_n` is low only in a write data phase with `e_i` high, a RAM address and `rst_n` high. A falling `rst_n` raises it in the same cycle, without waiting for a clock edge.
- R9: No select is active in the cycle after a clock edge that sampled `as_i` high (the address phase).
- R10: The tracker follows the start, latch, finish and restart transitions. In particular, a new strobe during a data phase starts the next cycle directly, without passing through the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_i | input | 1 | Address strobe, high while the low byte is on `ad_i` |
| e_i | input | 1 | Data-phase enable from the processor |
| rw_i | input | 1 | 1 = read, 0 = write |
| hi_addr_i | input | 8 | High address byte, steady for the whole cycle |
| ad_i | input | 8 | Shared low-address / data bus |
| addr_o | output | 16 | Full demultiplexed address |
| rom_cs_n | output | 1 | Program ROM chip select, active low |
| rom_oe_n | output | 1 | Program ROM output enable, active low |
| ram_cs_n | output | 1 | External RAM chip select, active low |
| ram_we_n | output | 1 | External RAM write enable, active low |
| int_sel_o | output | 1 | Internal RAM / I/O region marker, active high |
| latch_sel_n | output | 4 | Peripheral latch selects, active low |

## Verification
The assertions take the processor's bus protocol for granted. The high byte holds for a whole cycle, and `e_i` is never high in the same cycle as `as_i`. A strobe that ends the previous data phase arrives together with `e_i` going low. The bench drives only such cycles. A task opens each cycle with the strobe and enable changing together, then keeps `hi_addr_i` and `rw_i` fixed until the next cycle starts. Random addresses are biased toward the bottom kilobyte so that the four latch sub-ranges are reached often.

// File: rtl/membus_pkg.sv
package membus_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_ADDR = 2'd1,
        CYC_DATA = 2'd2
    } cyc_state_e;

    typedef struct packed {
        logic rom;
        logic ram;
        logic intr;
    } region_hit_t;

endpackage

// File: rtl/mbd_lo_latch.sv
module mbd_lo_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] lo_o
);

    logic [DW-1:0] lo_q;

    // Follows the shared bus while the strobe is high, then freezes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (capture_i) begin
            lo_q <= bus_i;
        end
    end

    assign lo_o = lo_q;

endmodule

// File: rtl/mbd_cycle_fsm.sv
module mbd_cycle_fsm
    import membus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_i,
    input  logic e_i,
    output logic addr_phase_o,
    output logic data_phase_o
);

    cyc_state_e state_q;
    cyc_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE: if (as_i) state_d = CYC_ADDR;            // start
            CYC_ADDR: if (!as_i) state_d = CYC_DATA;           // latch
            CYC_DATA: begin
                if (as_i) state_d = CYC_ADDR;                  // restart
                else if (!e_i) state_d = CYC_IDLE;             // finish
            end
            default: state_d = CYC_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        addr_phase_o = 1'b0;
        data_phase_o = 1'b0;
        unique case (state_q)
            CYC_IDLE: ;
            CYC_ADDR: addr_phase_o = 1'b1;
            CYC_DATA: data_phase_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mbd_region_decode.sv
module mbd_region_decode
    import membus_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          N_LATCH    = 4,
    parameter logic [AW-1:0] ROM_START  = 16'h2000,
    parameter logic [AW-1:0] RAM_START  = 16'h0400,
    parameter logic [AW-1:0] LATCH_BASE = 16'h0200,
    parameter int          LATCH_SPAN = 512
) (
    input  logic [AW-1:0]      addr_i,
    output region_hit_t        hit_o,
    output logic [N_LATCH-1:0] latch_hit_o
);

    localparam int SUB_SPAN = LATCH_SPAN / N_LATCH;

    logic [AW:0] a_ext;
    assign a_ext = {1'b0, addr_i};

    always_comb begin
        hit_o.rom  = a_ext >= {1'b0, ROM_START};
        hit_o.ram  = (a_ext >= {1'b0, RAM_START}) && (a_ext < {1'b0, ROM_START});
        hit_o.intr = a_ext < {1'b0, RAM_START};
    end

    for (genvar k = 0; k < N_LATCH; k++) begin : g_latch
        localparam logic [AW:0] LO = (AW+1)'(LATCH_BASE) + (AW+1)'(k * SUB_SPAN);
        localparam logic [AW:0] HI = LO + (AW+1)'(SUB_SPAN);
        assign latch_hit_o[k] = (a_ext >= LO) && (a_ext < HI);
    end

endmodule

// File: rtl/membus_decoder.sv
module membus_decoder
    import membus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int N_LATCH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               as_i,
    input  logic               e_i,
    input  logic               rw_i,
    input  logic [AW-DW-1:0]   hi_addr_i,
    input  logic [DW-1:0]      ad_i,
    output logic [AW-1:0]      addr_o,
    output logic               rom_cs_n,
    output logic               rom_oe_n,
    output logic               ram_cs_n,
    output logic               ram_we_n,
    output logic               int_sel_o,
    output logic [N_LATCH-1:0] latch_sel_n
);

    logic [DW-1:0]      lo_byte;
    logic               addr_phase;
    logic               data_phase;
    region_hit_t        hit;
    logic [N_LATCH-1:0] latch_hit;
    logic               wr_strobe;
    logic               rd_strobe;

    mbd_lo_latch #(.DW(DW)) u_lo (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (as_i),
        .bus_i     (ad_i),
        .lo_o      (lo_byte)
    );

    mbd_cycle_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_i         (as_i),
        .e_i          (e_i),
        .addr_phase_o (addr_phase),
        .data_phase_o (data_phase)
    );

    assign addr_o = {hi_addr_i, lo_byte};

    mbd_region_decode #(
        .AW      (AW),
        .N_LATCH (N_LATCH)
    ) u_dec (
        .addr_i      (addr_o),
        .hit_o       (hit),
        .latch_hit_o (latch_hit)
    );

    assign wr_strobe = data_phase && e_i && !rw_i;
    assign rd_strobe = data_phase && e_i && rw_i;

    always_comb begin
        rom_cs_n  = !(data_phase && hit.rom);
        ram_cs_n  = !(data_phase && hit.ram);
        int_sel_o = data_phase && hit.intr && !addr_phase;
        rom_oe_n  = !(rd_strobe && hit.rom);
        // reset gates the write path without passing through a register
        ram_we_n  = !(wr_strobe && hit.ram && rst_n);
    end

    for (genvar k = 0; k < N_LATCH; k++) begin : g_lsel
        assign latch_sel_n[k] = !(wr_strobe && latch_hit[k]);
    end

endmodule

// File: rtl/membus_decoder_chk.sv
module membus_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        as_i,
    input logic        e_i,
    input logic        rw_i,
    input logic [15:0] addr_o,
    input logic        rom_cs_n,
    input logic        rom_oe_n,
    input logic        ram_cs_n,
    input logic        ram_we_n,
    input logic        int_sel_o,
    input logic [3:0]  latch_sel_n
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (rom_cs_n && ram_cs_n && !int_sel_o && latch_sel_n == 4'hF)); // R1

    AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_i && $past(!as_i)) |-> $stable(addr_o[7:0])); // R2

    AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rom_cs_n, !ram_cs_n, int_sel_o}) <= 1); // R5

    AST_LATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~latch_sel_n)); // R6

    AST_LATCH_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_sel_n != 4'hF) |-> (!rw_i && e_i)); // R6

    AST_ROM_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_i |-> rom_oe_n); // R7

    AST_WE_RESET: assert property (@(posedge clk)
        !rst_n |-> ram_we_n); // R8

    AST_ADDR_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(as_i) |-> (rom_cs_n && ram_cs_n && latch_sel_n == 4'hF)); // R9

endmodule

bind membus_decoder membus_decoder_chk u_chk (.*);

// File: tb/membus_decoder_tb.sv
module membus_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_i = 1'b0;
    logic        e_i = 1'b0;
    logic        rw_i = 1'b1;
    logic [7:0]  hi_addr_i = '0;
    logic [7:0]  ad_i = '0;
    logic [15:0] addr_o;
    logic        rom_cs_n, rom_oe_n, ram_cs_n, ram_we_n, int_sel_o;
    logic [3:0]  latch_sel_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    membus_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .as_i(as_i), .e_i(e_i), .rw_i(rw_i),
        .hi_addr_i(hi_addr_i), .ad_i(ad_i), .addr_o(addr_o),
        .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .ram_cs_n(ram_cs_n),
        .ram_we_n(ram_we_n), .int_sel_o(int_sel_o), .latch_sel_n(latch_sel_n)
    );

    function automatic bit f_rom(input logic [15:0] a); return a >= 16'h2000; endfunction
    function automatic bit f_ram(input logic [15:0] a); return a >= 16'h0400 && a < 16'h2000; endfunction
    function automatic bit f_int(input logic [15:0] a); return a < 16'h0400; endfunction
    function automatic logic [3:0] f_latch(input logic [15:0] a, input bit wr);
        logic [3:0] v = 4'hF;
        if (wr && a >= 16'h0200 && a < 16'h0400) v[(a - 16'h0200) >> 7] = 1'b0;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_quiet(input string req);
        check(req, {rom_cs_n, rom_oe_n, ram_cs_n, ram_we_n, int_sel_o, latch_sel_n},
              {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF});
    endtask

    // One bus cycle: address phase, data phase, optional finish.
    task automatic bus_cycle(input logic [15:0] a, input bit wr, input bit finish);
        @(negedge clk);
        as_i = 1'b1; e_i = 1'b0; rw_i = !wr; hi_addr_i = a[15:8]; ad_i = a[7:0];
        @(negedge clk);
        // address phase: R9 quiet, R2 captured
        check("R9 addr phase quiet", {rom_cs_n, ram_cs_n, latch_sel_n}, {1'b1, 1'b1, 4'hF});
        check("R2 low byte captured", addr_o, a);
        as_i = 1'b0; e_i = 1'b1; ad_i = 8'($urandom);
        @(negedge clk);
        check("R3 rom select", rom_cs_n, !f_rom(a));
        check("R4 ram select", ram_cs_n, !f_ram(a));
        check("R5 internal region", int_sel_o, f_int(a));
        check("R6 latch selects", latch_sel_n, f_latch(a, wr));
        check("R7 rom oe", rom_oe_n, !(f_rom(a) && !wr));
        check("R8 ram we", ram_we_n, !(f_ram(a) && wr));
        ad_i = ~ad_i;
        #1;
        check("R2 address held in data phase", addr_o, a);
        if (finish) begin
            @(negedge clk);
            e_i = 1'b0;
            #1;
            check("R6 latch release", latch_sel_n, 4'hF);
            check("R8 we release", ram_we_n, 1'b1);
            @(negedge clk);
            idle_quiet("R10 finish to idle");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R10 watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] dirs [12];
        void'($urandom(32'd20240611));
        dirs = '{16'h0000, 16'h01FF, 16'h0200, 16'h027F, 16'h0280, 16'h0300,
                 16'h0380, 16'h03FF, 16'h0400, 16'h1FFF, 16'h2000, 16'hFFFF};
        repeat (3) @(negedge clk);
        idle_quiet("R1 reset quiet");
        as_i = 1'b1; ad_i = 8'hA5; hi_addr_i = 8'h05; rw_i = 1'b0;
        @(negedge clk);
        idle_quiet("R1 reset quiet with strobe");
        as_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (dirs[i]) begin
            bus_cycle(dirs[i], 1'b0, 1'b1);
            bus_cycle(dirs[i], 1'b1, 1'b1);
        end

        // restart: data phase straight into next address phase
        bus_cycle(16'h0290, 1'b1, 1'b0);
        bus_cycle(16'h0A00, 1'b1, 1'b1);
        check("R10 restart reached data phase", ram_cs_n, 1'b1);

        for (int i = 0; i < 300; i++) begin
            logic [15:0] a = 16'($urandom);
            if (($urandom & 1) == 0) a = a & 16'h03FF;
            bus_cycle(a, bit'($urandom & 1), bit'(($urandom % 4) != 0));
        end

        // reset during a RAM write drops the write enable at once
        bus_cycle(16'h0800, 1'b1, 1'b0);
        check("R8 we active before reset", ram_we_n, 1'b0);
        rst_n = 1'b0;
        #0.5;
        check("R8 reset blocks write", ram_we_n, 1'b1);
        e_i = 1'b0;
        @(negedge clk);
        idle_quiet("R1 reset quiet mid cycle");
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule